// File: doc/BRIEF.md
# Master Raster Timing Generator

This block produces the complete horizontal and vertical raster timing of an interlaced video encoder running as timing master. It counts 13.5 MHz pixel slots, which arrive as a clock enable on a faster system clock, and it keeps track of the position within the line, the line number within the frame and the field within the colour field sequence. From that position it decodes the following outputs: an active-low composite sync, line and field sync pulses for the upstream decoder, a field flag with a field sequence number, blanking, a burst/clamp gate and a pedestal window.

A standard-select input chooses between the 525-line and the 625-line geometry. A 10-bit offset, supplied as a 2-bit high part and an 8-bit low part, moves the falling edge of the line sync pulse relative to the first active chroma sample. The downstream encoder consumes the gates. The line sync pulse tells the source when to start sending pixel data.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal position advances by one on each cycle with `pix_en` high. It wraps to 0 after `L525`-1 in 525-line mode (`std_625`=0) and after `L625`-1 in 625-line mode (`std_625`=1).
- R2: Lines are numbered from 1. The line number advances when the horizontal position wraps, and it returns to 1 after line 525 or line 625.
- R3: `field2` is 1 from line 264 (525) or line 313 (625) through the last line, and 0 otherwise. `field_seq` increments at the start of each field, that is on entering line 1 or the first line of field 2. It wraps modulo 4 in 525-line mode and modulo 8 in 625-line mode.
- R4: In 525-line mode, `blank` is 1 on all of lines 1–9 and 264–272 and on the second half of line 263 (position ≥ `L525`/2). It is also 1 at any position below `ACT_START`, and 0 elsewhere.
- R5: In 625-line mode, `blank` is 1 on all of lines 1–5, 311–318 and 624–625 and on the second half of line 623. It is also 1 at any position below `ACT_START`, and 0 elsewhere.
- R6: `burst_gate` is 1 only at positions `BURST_START` to `BURST_START+BURST_LEN-1` on lines 10–263 and 273–525 (525), or on lines 6–310 and 319–623 (625).
- R7: `ped_win` is 1 only in 525-line mode with `ped_en`=1, at positions ≥ `ACT_START`, on lines 23–262 and 286–525.
- R8: `hs_n` falls at position F = (offset − `OFS_ZERO` + `ACT_START`) mod line length, where offset = {`hs_ofs_hi`,`hs_ofs_lo`}. It stays low for `HS_W` positions, so an offset equal to `OFS_ZERO` (default 0x07E) puts the falling edge on the first active sample.
- R9: When F + `HS_W` exceeds the line length, `hs_n` returns high at position 0 of the next line, which shortens the pulse.
- R10: `vs_n` is low on lines 1–3. It is also low from the second half of line S through the first half of line S+3, where S is 263 (525) or 313 (625).
- R11: Outside the fully blanked lines of R4/R5, `csync_n` is low for the first `CS_W` positions of the line. On those blanked lines it is low for the first half-line minus `CS_W` positions of each half-line.
- R12: After reset the position is 0 on line 1 with `field_seq`=0, so `csync_n`, `vs_n` and `field2` read 0.
- R13: While `pix_en` is low, the position, line and field do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | 13.5 MHz pixel slot enable |
| std_625 | input | 1 | 0 = 525-line, 1 = 625-line geometry |
| ped_en | input | 1 | Pedestal window enable (525 only) |
| hs_ofs_hi | input | 2 | Line sync offset, bits 9:8 |
| hs_ofs_lo | input | 8 | Line sync offset, bits 7:0 |
| csync_n | output | 1 | Composite sync, active low |
| hs_n | output | 1 | Line sync, active low |
| vs_n | output | 1 | Field sync, active low |
| field2 | output | 1 | Second field of the frame |
| field_seq | output | 3 | Field number in colour sequence |
| blank | output | 1 | Blanking |
| burst_gate | output | 1 | Burst/clamp gate |
| ped_win | output | 1 | Pedestal window |

## Verification
The bench builds the block with 32-slot and 34-slot lines, 6-slot line sync, 5-slot composite sync, active video from slot 10 and a 3-slot burst window. All line numbers keep their real values. The short lines let a run cover two full 525-line frames and four full 625-line frames, so the bench sees every line window and every half-line edge, the wrap of the 4-field and 8-field sequences, and HS offsets that push the pulse across the end of the line. Throughout the run the enable is dropped on one slot in nine.

// File: rtl/raster_pkg.sv
package raster_pkg;
    localparam int LINE_W    = 10;
    localparam int SEQ_W     = 3;
    localparam int LINES_525 = 525;
    localparam int LINES_625 = 625;
    localparam int F2_525    = 264;
    localparam int F2_625    = 313;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [SEQ_W-1:0]  fseq;
    } vstate_t;

    function automatic logic in_win(input logic [LINE_W-1:0] ln, input int lo, input int hi);
        return (int'(ln) >= lo) && (int'(ln) <= hi);
    endfunction
endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
    parameter int L525      = 858,
    parameter int L625      = 864,
    parameter int HS_W      = 64,
    parameter int ACT_START = 122,
    parameter int OFS_ZERO  = 126,
    parameter int HW        = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic          std_625,
    input  logic [9:0]    hs_ofs,
    output logic [HW-1:0] h_q,
    output logic          eol,
    output logic          hs_n
);
    localparam int SW     = $clog2(1024 + 2 * L625 + 2 * L525) + 1;
    localparam int ADD525 = ACT_START + L525 - (OFS_ZERO % L525);
    localparam int ADD625 = ACT_START + L625 - (OFS_ZERO % L625);

    typedef struct packed {
        logic [HW-1:0] h;
    } hstate_t;

    hstate_t       st_d, st_q;
    logic [HW-1:0] last;
    logic [SW-1:0] sum525, sum625;
    logic [HW:0]   fall, hx;

    // Next-state logic: horizontal position and sync pulse placement
    always_comb begin
        last   = std_625 ? HW'(L625 - 1) : HW'(L525 - 1);
        st_d   = st_q;
        eol    = pix_en && (st_q.h == last);
        if (pix_en)
            st_d.h = eol ? '0 : st_q.h + 1'b1;
        sum525 = SW'(hs_ofs) + SW'(ADD525);
        sum625 = SW'(hs_ofs) + SW'(ADD625);
        fall   = std_625 ? (HW+1)'(sum625 % SW'(L625)) : (HW+1)'(sum525 % SW'(L525));
        hx     = {1'b0, st_q.h};
        hs_n   = !((hx >= fall) && (hx < fall + (HW+1)'(HS_W)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h_q = st_q.h;

    p_h_bound_r1: assert property (@(posedge clk) disable iff (!rst_n) h_q <= last);
    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n) !pix_en |=> $stable(h_q));
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eol,
    input  logic              std_625,
    output logic [LINE_W-1:0] line_q,
    output logic [SEQ_W-1:0]  fseq_q,
    output logic              field2
);
    vstate_t           st_d, st_q;
    logic [LINE_W-1:0] nlines, f2line;
    logic [SEQ_W-1:0]  mask;

    // Next-state logic: line number and field sequence
    always_comb begin
        nlines = std_625 ? LINE_W'(LINES_625) : LINE_W'(LINES_525);
        f2line = std_625 ? LINE_W'(F2_625) : LINE_W'(F2_525);
        mask   = std_625 ? SEQ_W'(7) : SEQ_W'(3);
        st_d   = st_q;
        if (eol) begin
            st_d.line = (st_q.line == nlines) ? LINE_W'(1) : st_q.line + 1'b1;
            if ((st_d.line == LINE_W'(1)) || (st_d.line == f2line))
                st_d.fseq = (st_q.fseq + 1'b1) & mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.line <= LINE_W'(1);
            st_q.fseq <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_q = st_q.line;
    assign fseq_q = st_q.fseq;
    assign field2 = st_q.line >= f2line;

    p_line_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q >= LINE_W'(1)) && (line_q <= nlines));
    p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eol && (line_q != nlines)) |=> (line_q == $past(line_q) + 1'b1));
    p_fseq_bound_r3: assert property (@(posedge clk) disable iff (!rst_n) fseq_q <= mask);
endmodule

// File: rtl/raster_vdecode.sv
module raster_vdecode
    import raster_pkg::*;
#(
    parameter int L525        = 858,
    parameter int L625        = 864,
    parameter int CS_W        = 63,
    parameter int ACT_START   = 122,
    parameter int BURST_START = 70,
    parameter int BURST_LEN   = 34,
    parameter int HW          = 10
) (
    input  logic [HW-1:0]     h,
    input  logic [LINE_W-1:0] line,
    input  logic              std_625,
    input  logic              ped_en,
    output logic              blank,
    output logic              burst_gate,
    output logic              ped_win,
    output logic              vs_n,
    output logic              csync_n
);
    int   hi, len, half, vs2;
    logic vint, half_blank, burst_lines, ped_lines, vs_low;

    // Line-window and half-line decode of the current position
    always_comb begin
        hi   = int'(h);
        len  = std_625 ? L625 : L525;
        half = len / 2;
        vs2  = std_625 ? 313 : 263;
        if (std_625) begin
            vint        = in_win(line, 1, 5) || in_win(line, 311, 318) || in_win(line, 624, 625);
            half_blank  = in_win(line, 623, 623) && (hi >= half);
            burst_lines = in_win(line, 6, 310) || in_win(line, 319, 623);
        end else begin
            vint        = in_win(line, 1, 9) || in_win(line, 264, 272);
            half_blank  = in_win(line, 263, 263) && (hi >= half);
            burst_lines = in_win(line, 10, 263) || in_win(line, 273, 525);
        end
        ped_lines  = in_win(line, 23, 262) || in_win(line, 286, 525);
        blank      = vint || half_blank || (hi < ACT_START);
        burst_gate = burst_lines && (hi >= BURST_START) && (hi < BURST_START + BURST_LEN);
        ped_win    = !std_625 && ped_en && ped_lines && (hi >= ACT_START);
        vs_low     = in_win(line, 1, 3)
                  || (in_win(line, vs2, vs2) && (hi >= half))
                  || in_win(line, vs2 + 1, vs2 + 2)
                  || (in_win(line, vs2 + 3, vs2 + 3) && (hi < half));
        vs_n       = !vs_low;
        if (vint)
            csync_n = !((hi < half - CS_W) || ((hi >= half) && (hi < len - CS_W)));
        else
            csync_n = !(hi < CS_W);
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int L525        = 858,
    parameter int L625        = 864,
    parameter int HS_W        = 64,
    parameter int CS_W        = 63,
    parameter int ACT_START   = 122,
    parameter int BURST_START = 70,
    parameter int BURST_LEN   = 34,
    parameter int OFS_ZERO    = 126
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pix_en,
    input  logic       std_625,
    input  logic       ped_en,
    input  logic [1:0] hs_ofs_hi,
    input  logic [7:0] hs_ofs_lo,
    output logic       csync_n,
    output logic       hs_n,
    output logic       vs_n,
    output logic       field2,
    output logic [2:0] field_seq,
    output logic       blank,
    output logic       burst_gate,
    output logic       ped_win
);
    localparam int LMAX = (L625 > L525) ? L625 : L525;
    localparam int HW   = $clog2(LMAX);

    logic [HW-1:0]     h;
    logic [LINE_W-1:0] line;
    logic              eol;

    raster_hcount #(
        .L525(L525), .L625(L625), .HS_W(HS_W), .ACT_START(ACT_START),
        .OFS_ZERO(OFS_ZERO), .HW(HW)
    ) u_h (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .std_625(std_625),
        .hs_ofs({hs_ofs_hi, hs_ofs_lo}), .h_q(h), .eol(eol), .hs_n(hs_n)
    );

    raster_vcount u_v (
        .clk(clk), .rst_n(rst_n), .eol(eol), .std_625(std_625),
        .line_q(line), .fseq_q(field_seq), .field2(field2)
    );

    raster_vdecode #(
        .L525(L525), .L625(L625), .CS_W(CS_W), .ACT_START(ACT_START),
        .BURST_START(BURST_START), .BURST_LEN(BURST_LEN), .HW(HW)
    ) u_d (
        .h(h), .line(line), .std_625(std_625), .ped_en(ped_en),
        .blank(blank), .burst_gate(burst_gate), .ped_win(ped_win),
        .vs_n(vs_n), .csync_n(csync_n)
    );

    p_ped_525_only_r7: assert property (@(posedge clk) disable iff (!rst_n) std_625 |-> !ped_win);
    p_burst_outside_vs_r6: assert property (@(posedge clk) disable iff (!rst_n) burst_gate |-> vs_n);
    p_csync_idle_r11: assert property (@(posedge clk) disable iff (!rst_n) !pix_en |=> $stable(csync_n));
endmodule

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
    localparam int L5 = 32, L6 = 34, HSW = 6, CSW = 5, ACT = 10, BS = 6, BL = 3, OZ = 126;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0, pix_en = 1'b0, std_625 = 1'b0, ped_en = 1'b0;
    logic [1:0] hs_ofs_hi = 2'd0;
    logic [7:0] hs_ofs_lo = 8'd126;
    logic       csync_n, hs_n, vs_n, field2, blank, burst_gate, ped_win;
    logic [2:0] field_seq;

    raster_timing_gen #(
        .L525(L5), .L625(L6), .HS_W(HSW), .CS_W(CSW), .ACT_START(ACT),
        .BURST_START(BS), .BURST_LEN(BL), .OFS_ZERO(OZ)
    ) uut (.*);

    typedef struct packed {
        logic cs, hs, vs, f2;
        logic [2:0] fs;
        logic bl, bu, pd;
    } exp_t;

    exp_t q[$];
    int   nchk = 0, nerr = 0;
    int   mh, mline, mfs;

    task automatic check(string req, string what, int act, int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d (line %0d pos %0d)", req, what, act, expv, mline, mh);
        end
    endtask

    function automatic bit win(int v, int lo, int hi);
        return v >= lo && v <= hi;
    endfunction

    function automatic exp_t model(int ofs);
        exp_t e;
        int   len  = std_625 ? L6 : L5;
        int   half = len / 2;
        int   f2   = std_625 ? 313 : 264;
        int   s    = std_625 ? 313 : 263;
        int   f    = (ofs - OZ + ACT) % len;
        bit   full;
        if (f < 0) f += len;
        full = std_625 ? (win(mline, 1, 5) || win(mline, 311, 318) || mline >= 624)
                       : (win(mline, 1, 9) || win(mline, 264, 272));
        e.hs = !(mh >= f && mh < f + HSW);
        e.vs = !(mline <= 3 || (mline == s && mh >= half) || win(mline, s + 1, s + 2)
                 || (mline == s + 3 && mh < half));
        e.f2 = mline >= f2;
        e.fs = 3'(mfs);
        e.bl = full || mh < ACT || (mline == (std_625 ? 623 : 263) && mh >= half);
        e.bu = (std_625 ? (win(mline, 6, 310) || win(mline, 319, 623))
                        : (win(mline, 10, 263) || win(mline, 273, 525))) && mh >= BS && mh < BS + BL;
        e.pd = !std_625 && ped_en && mh >= ACT && (win(mline, 23, 262) || win(mline, 286, 525));
        if (full) e.cs = !(mh < half - CSW || (mh >= half && mh < len - CSW));
        else      e.cs = !(mh < CSW);
        return e;
    endfunction

    // Monitor: pops expected items and compares a little after the falling edge
    always begin
        exp_t e;
        @(negedge clk);
        #1;
        while (q.size() > 0) begin
            e = q.pop_front();
            check("R11 (R1 R2 R13 position)", "csync_n", csync_n, e.cs);
            check("R8 R9", "hs_n", hs_n, e.hs);
            check("R10", "vs_n", vs_n, e.vs);
            check("R3", "field2", field2, e.f2);
            check("R3", "field_seq", field_seq, e.fs);
            check(std_625 ? "R5" : "R4", "blank", blank, e.bl);
            check("R6", "burst_gate", burst_gate, e.bu);
            check("R7", "ped_win", ped_win, e.pd);
        end
    end

    task automatic run(logic s, int cycles);
        int ofs_list[6] = '{126, 146, 0, 1023, 140, 121};
        int ofs;
        rst_n = 1'b0; pix_en = 1'b0; std_625 = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mh = 0; mline = 1; mfs = 0;
        #1;
        // R12: reset position is line 1, slot 0, field sequence 0
        check("R12", "field_seq", field_seq, 0);
        check("R12", "field2", field2, 0);
        check("R12", "csync_n", csync_n, 0);
        check("R12", "vs_n", vs_n, 0);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            ofs       = ofs_list[(i / 4000) % 6];
            hs_ofs_hi = 2'(ofs >> 8);
            hs_ofs_lo = 8'(ofs);
            ped_en    = ((i / 3000) % 2) == 0;
            pix_en    = (i % 9) != 8;
            q.push_back(model(ofs));
            if (pix_en) begin
                mh++;
                if (mh == (s ? L6 : L5)) begin
                    mh = 0;
                    mline++;
                    if (mline > (s ? 625 : 525)) mline = 1;
                    if (mline == 1 || mline == (s ? 313 : 264)) mfs = (mfs + 1) % (s ? 8 : 4);
                end
            end
        end
        @(negedge clk);
        pix_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        run(1'b0, 38500);
        run(1'b1, 96500);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule